// File: doc/BRIEF.md
# Supply Reset and Watchdog Supervisor

This block merges three reset sources into one active-low system reset: a manual reset pin, a software watchdog, and per-channel supply fault flags. The flags arrive from external comparators. Each channel supplies an under-voltage flag and an over-voltage flag. A per-channel select bit picks which of the two counts as that channel's fault. A per-channel enable bit decides whether that fault may pull reset.

Every reset request is stretched by a programmable timeout. All timing is counted in ticks of a one-cycle, 1 ms strobe. The watchdog has a programmable period. Falling edges on a kick input clear it. A live status vector shows every channel that is currently faulted, whether or not that channel is enabled.

The block also asserts reset for one timeout after its own asynchronous reset is released.

Top module: `supply_reset_supervisor`

## Requirements
- R1: While `mr_ni` is low, `rst_no` is low in the same cycle, whatever the other inputs and settings are.
- R2: After the last request ends, `rst_no` stays low for exactly T ticks and then goes high. T is set by `rto_code_i`: 0 gives 25, 1 gives 50, 2 gives 100, 3 gives 200.
- R3: Any request that arrives while the timeout is counting restarts the count from zero.
- R4: Watchdog period P in ticks is set by `wd_code_i`: 000 and 001 turn the watchdog off; 010 and 011 give 400; 100 gives 800; 101 gives 1600; 110 gives 3200; 111 gives 6400.
- R5: The kick input passes through two synchronizer flops. Only a high-to-low transition clears the watchdog; the effect lands three clock edges after the change. A rising edge, or a kick held low, does not prevent expiry.
- R6: On expiry, reset is requested for one cycle and then stretched, so `rst_no` is low for T+1 cycles. The watchdog holds at zero while reset is active and restarts from zero when `rst_no` returns high. With no kicks this gives a train of P cycles high and T+1 cycles low.
- R7: Channel i's fault is `ov_i[i]` when `ov_sel_i[i]`=1 and `uv_i[i]` when it is 0. The fault pulls `rst_no` low in the same cycle only when `trig_en_i[i]`=1; with the enable clear it has no effect on `rst_no`.
- R8: When an enabled fault clears, `rst_no` stays low for T ticks and then releases, as in R2.
- R9: `fault_o[i]` shows channel i's selected fault combinationally, regardless of `trig_en_i[i]`.
- R10: `rst_no` is low while `rst_ni` is low, and stays low for T ticks after `rst_ni` is released.
- R11: The timeout and watchdog counters advance only on cycles where `tick_i` is high.
- R12: If a kick falling edge and the watchdog's terminal count meet at the same clock edge, the kick wins: there is no reset, and a full new period starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle 1 ms timing strobe |
| mr_ni | input | 1 | Manual reset, active low, synchronous to clk_i |
| kick_i | input | 1 | Watchdog kick, asynchronous |
| uv_i | input | 4 | Under-voltage flags per channel |
| ov_i | input | 4 | Over-voltage flags per channel |
| trig_en_i | input | 4 | Per-channel reset trigger enable |
| ov_sel_i | input | 4 | Per-channel condition select (1 = over-voltage) |
| rto_code_i | input | 2 | Reset timeout code |
| wd_code_i | input | 3 | Watchdog period code |
| rst_no | output | 1 | System reset, active low |
| fault_o | output | 4 | Live per-channel fault status |

## Verification
The kick falling edge and the watchdog terminal count can meet at the same clock edge. The bench first measures the free-running period with no kicks. It then drops the kick input three edges before the known terminal edge, so the synchronized falling edge reaches the counter exactly on the terminal cycle. The correct result is no reset at that edge and a full new period counted from it. A fresh request during a running timeout is a second collision, and it is judged by the total length of the stretched low time.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  // reset stretch length in ticks: base * 1, 2, 4, 8
  function automatic int unsigned rto_ticks(input int unsigned base, input logic [1:0] code);
    return base << code;
  endfunction

  // watchdog enabled for codes 010..111
  function automatic logic wd_on(input logic [2:0] code);
    return code[2] | code[1];
  endfunction

  // watchdog period in ticks; 010 and 011 share the base period
  function automatic int unsigned wd_ticks(input int unsigned base, input logic [2:0] code);
    if (code <= 3'd3) return base;
    return base << (code - 3'd3);
  endfunction

endpackage

// File: rtl/rsup_fault.sv
module rsup_fault #(
  parameter int N_CH = 4
) (
  input  logic [N_CH-1:0] uv_i,
  input  logic [N_CH-1:0] ov_i,
  input  logic [N_CH-1:0] trig_en_i,
  input  logic [N_CH-1:0] ov_sel_i,
  output logic [N_CH-1:0] status_o,
  output logic            req_o
);
  logic [N_CH-1:0] armed;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign status_o[i] = ov_sel_i[i] ? ov_i[i] : uv_i[i];
    assign armed[i]    = status_o[i] & trig_en_i[i];
  end

  assign req_o = |armed;
endmodule

// File: rtl/rsup_stretch.sv
module rsup_stretch #(
  parameter int unsigned BASE = 25
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       req_i,
  input  logic [1:0] code_i,
  output logic       hold_o
);
  localparam int CW = $clog2(BASE * 8 + 1);

  logic          hold_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;

  assign lim_m1 = CW'(rsup_pkg::rto_ticks(BASE, code_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (req_i) begin
      hold_q <= 1'b1;
      cnt_q  <= '0;
    end else if (hold_q && tick_i) begin
      if (cnt_q >= lim_m1) begin
        hold_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign hold_o = hold_q;

  // R3: any request restarts the stretch from zero
  a_r3_req_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (hold_q && cnt_q == '0));

  // R11: no tick, no progress
  a_r11_no_tick_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q && !req_i && !tick_i) |=> (hold_q && $stable(cnt_q)));
endmodule

// File: rtl/rsup_wdog.sv
module rsup_wdog #(
  parameter int unsigned BASE = 400
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       kick_i,
  input  logic       rst_active_i,
  input  logic [2:0] code_i,
  output logic       expire_o
);
  localparam int CW = $clog2(BASE * 16 + 1);

  logic [2:0]    ksh_q;   // [0],[1] synchronizer, [2] edge history
  logic          kick_fall;
  logic          wd_en;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim_m1;
  logic          exp_q;

  assign kick_fall = ksh_q[2] & ~ksh_q[1];
  assign wd_en     = rsup_pkg::wd_on(code_i);
  assign lim_m1    = CW'(rsup_pkg::wd_ticks(BASE, code_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ksh_q <= 3'b111;
    else         ksh_q <= {ksh_q[1:0], kick_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (rst_active_i || !wd_en) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick_fall) begin
      // kick beats a coincident terminal count
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_i && cnt_q >= lim_m1) begin
      cnt_q <= '0;
      exp_q <= 1'b1;
    end else begin
      exp_q <= 1'b0;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = exp_q;

  // R4: disabled watchdog never expires
  a_r4_off_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !exp_q);

  // R5/R12: a falling kick outside reset clears the count and blocks expiry
  a_r5_kick_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kick_fall && !rst_active_i) |=> (cnt_q == '0 && !exp_q));

  // R6: counter parked at zero while reset is active
  a_r6_parked_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_active_i |=> (cnt_q == '0));
endmodule

// File: rtl/supply_reset_supervisor.sv
module supply_reset_supervisor #(
  parameter int          N_CH     = 4,
  parameter int unsigned RTO_BASE = 25,
  parameter int unsigned WD_BASE  = 400
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            mr_ni,
  input  logic            kick_i,
  input  logic [N_CH-1:0] uv_i,
  input  logic [N_CH-1:0] ov_i,
  input  logic [N_CH-1:0] trig_en_i,
  input  logic [N_CH-1:0] ov_sel_i,
  input  logic [1:0]      rto_code_i,
  input  logic [2:0]      wd_code_i,
  output logic            rst_no,
  output logic [N_CH-1:0] fault_o
);
  logic fault_req;
  logic wd_expire;
  logic hold;
  logic req;
  logic rst_active;

  rsup_fault #(.N_CH(N_CH)) u_fault (
    .uv_i      (uv_i),
    .ov_i      (ov_i),
    .trig_en_i (trig_en_i),
    .ov_sel_i  (ov_sel_i),
    .status_o  (fault_o),
    .req_o     (fault_req)
  );

  // manual reset is never masked
  assign req        = ~mr_ni | fault_req | wd_expire;
  assign rst_active = req | hold;
  assign rst_no     = ~rst_active;

  rsup_stretch #(.BASE(RTO_BASE)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .req_i  (req),
    .code_i (rto_code_i),
    .hold_o (hold)
  );

  rsup_wdog #(.BASE(WD_BASE)) u_wdog (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .kick_i       (kick_i),
    .rst_active_i (rst_active),
    .code_i       (wd_code_i),
    .expire_o     (wd_expire)
  );

  // R1: manual reset forces the output
  a_r1_manual_forces: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mr_ni |-> !rst_no);

  // R7: an enabled, active fault forces the output
  a_r7_enabled_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(fault_o & trig_en_i)) |-> !rst_no);

  // R8: reset persists after an enabled fault clears
  a_r8_fault_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_req |=> !rst_no);

  // R6: expiry drives reset
  a_r6_expiry_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |-> !rst_no);
endmodule

// File: tb/supply_reset_supervisor_tb.sv
module supply_reset_supervisor_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni, tick, mr_n, kick;
  logic [3:0] uv, ov, en, sel;
  logic [1:0] rto;
  logic [2:0] wdc;
  logic       rst_no;
  logic [3:0] fault;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  supply_reset_supervisor dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .mr_ni(mr_n), .kick_i(kick),
    .uv_i(uv), .ov_i(ov), .trig_en_i(en), .ov_sel_i(sel),
    .rto_code_i(rto), .wd_code_i(wdc), .rst_no(rst_no), .fault_o(fault)
  );

  function automatic int rto_len(input int c);
    return 25 << c;
  endfunction

  function automatic int wd_len(input int c);
    if (c <= 3) return 400;
    return 400 << (c - 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // current sample is index 0 of a run of n samples at level lvl
  task automatic run(input int n, input int lvl, input string tag);
    repeat (n - 1) @(negedge clk);
    chk(tag, rst_no, lvl);
    @(negedge clk);
    chk(tag, rst_no, 1 - lvl);
  endtask

  task automatic mr_pulse(input int n);
    mr_n = 1'b0;
    #1;
    chk("R1", rst_no, 0);
    repeat (n) @(negedge clk);
    mr_n = 1'b1;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lows;
    logic [3:0] exp_f;
    void'($urandom(32'd17));
    rst_ni = 0; tick = 1; mr_n = 1; kick = 1;
    uv = 0; ov = 0; en = 0; sel = 0; rto = 0; wdc = 0;
    repeat (3) @(negedge clk);
    chk("R10", rst_no, 0);
    chk("R9", fault, 0);
    rst_ni = 1;
    run(25, 0, "R10");

    // R2: every timeout code
    for (int c = 0; c < 4; c++) begin
      rto = c[1:0];
      mr_pulse(5);
      run(rto_len(c), 0, "R2");
    end

    // R3: new request mid-timeout restarts it
    rto = 2'd1;
    mr_pulse(3);
    repeat (20) @(negedge clk);
    chk("R3", rst_no, 0);
    mr_pulse(1);
    run(50, 0, "R3");

    // R11: no ticks, no release
    rto = 2'd0;
    tick = 0;
    mr_pulse(2);
    repeat (100) @(negedge clk);
    chk("R11", rst_no, 0);
    tick = 1;
    run(25, 0, "R11");

    // R9/R7: random fault patterns
    for (int i = 0; i < 40; i++) begin
      uv = 4'($urandom); ov = 4'($urandom); en = 4'($urandom); sel = 4'($urandom);
      #1;
      exp_f = (sel & ov) | (~sel & uv);
      chk("R9", fault, exp_f);
      if (|(exp_f & en)) chk("R7", rst_no, 0);
      @(negedge clk);
    end
    uv = 0; ov = 0; en = 0; sel = 0;
    repeat (30) @(negedge clk);
    chk("R8", rst_no, 1);

    // R7: disabled faults have no effect, status still visible
    uv = 4'hF;
    #1;
    chk("R9", fault, 4'hF);
    lows = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!rst_no) lows++;
    end
    chk("R7", lows, 0);
    sel = 4'hF;
    #1;
    chk("R7", fault, 4'h0);
    sel = 0; uv = 0;
    @(negedge clk);

    // R7/R8: enabled UV on channel 2
    en = 4'b0100; uv = 4'b0100;
    #1;
    chk("R7", rst_no, 0);
    repeat (5) @(negedge clk);
    uv = 0;
    run(25, 0, "R8");

    // R7/R8: enabled OV on channel 1
    en = 4'b0010; sel = 4'b0010; ov = 4'b0010; uv = 4'b0010;
    #1;
    chk("R7", rst_no, 0);
    repeat (4) @(negedge clk);
    ov = 0;
    run(25, 0, "R8");
    en = 0; sel = 0; uv = 0;

    // R4/R6: every enabled period, no kicks
    for (int c = 2; c < 8; c++) begin
      wdc = c[2:0];
      mr_pulse(2);
      run(25, 0, "R6");
      run(wd_len(c), 1, "R4");
    end
    wdc = 0;

    // R4: off codes never reset
    for (int c = 0; c < 2; c++) begin
      wdc = c[2:0];
      mr_pulse(2);
      run(25, 0, "R2");
      lows = 0;
      for (int i = 0; i < 600; i++) begin
        @(negedge clk);
        if (!rst_no) lows++;
      end
      chk("R4", lows, 0);
    end

    // R5/R6: kick edges
    wdc = 3'd3;
    kick = 0;
    mr_pulse(2);
    run(25, 0, "R6");
    repeat (100) @(negedge clk);
    kick = 1;                  // rising edge must not clear
    run(300, 1, "R5");
    run(26, 0, "R6");
    repeat (200) @(negedge clk);
    kick = 0;                  // falling edge clears, lands 3 edges later
    run(403, 1, "R5");
    run(26, 0, "R6");
    run(400, 1, "R5");         // held low: train continues
    kick = 1;
    run(26, 0, "R6");

    // R12: kick falling edge on the terminal edge
    repeat (397) @(negedge clk);
    kick = 0;
    run(403, 1, "R12");
    wdc = 0;
    kick = 1;

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule